// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block sits beside the load/store decode stage and decides, within the same cycle, whether a decoded memory access can be carried out. It looks at the access class, the effective address, and the byte count. It also looks at the direct-store segment flags of the first and last byte, the page cache attributes, the data-cache configuration and the little-endian state bit. It raises an alignment fault when any class-specific rule rejects the access.

The rules depend on the class:
- Floating-point accesses must be word-aligned and must stay out of direct-store segments.
- Multiple-word and reservation accesses must be word-aligned.
- Elementary, multiple and string accesses must not cross a segment boundary into a segment with a different direct-store flag.
- Block zeroing needs a cacheable, copy-back target and a copy-back data cache.
- External-control word accesses must be word-aligned.
- Multiple and string accesses are refused when the little-endian bit is set.

An elementary access that is misaligned in little-endian mode is accepted. The block holds no state. Each rule drives one bit of a hit vector. A fixed-priority encoder then reports the lowest-numbered rule that matched.

Top module: `align_check`

## Requirements
- R1: A floating-point access (class 1) whose first-byte or last-byte direct-store flag is set reports cause 1.
- R2: A floating-point access whose address bits [1:0] are not zero faults, with cause 2 when R1 does not match.
- R3: A multiple-word access (class 2) or a reservation access (class 3) whose address bits [1:0] are not zero reports cause 3.
- R4: An elementary (class 0), multiple (class 2) or string (class 4) access faults with cause 4 (absent a lower cause) when the top 4 address bits of its first byte (address) and its last byte (address + size - 1, where size 0 counts as 1) differ and the two direct-store flags differ.
- R5: A block-zero access (class 5) reports cause 5 when the page is write-through or cache-inhibited, or when the data-cache mode is 0 (absent) or 1 (write-through). Modes 2 and 3 (copy-back) give no fault.
- R6: An external-control word access (class 6) whose address bits [1:0] are not zero reports cause 6.
- R7: A multiple or string access with the little-endian bit set faults, with cause 7 when no lower cause matches.
- R8: An elementary access faults only through R4. Misalignment, the little-endian bit and the cache attributes have no effect on it.
- R9: When several rules match, the cause is the lowest-numbered one. The fault flag is 1 exactly when the cause is non-zero. Both outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_class_i | input | 3 | Access class: 0 elementary, 1 floating-point, 2 multiple-word, 3 reservation, 4 string, 5 block zero, 6 external-control word, 7 unused |
| addr_i | input | 32 | Effective address of the first byte |
| size_i | input | 8 | Access length in bytes (0 treated as 1) |
| ds_first_i | input | 1 | Direct-store flag of the segment holding the first byte |
| ds_last_i | input | 1 | Direct-store flag of the segment holding the last byte |
| wthru_i | input | 1 | Page is write-through required |
| cinhib_i | input | 1 | Page is caching-inhibited |
| dc_mode_i | input | 2 | Data cache: 0 absent, 1 write-through, 2 or 3 copy-back |
| le_mode_i | input | 1 | Little-endian state bit |
| fault_o | output | 1 | Alignment fault |
| cause_o | output | 3 | Lowest-numbered matching rule, 0 when none |

## Verification
The segment-split rule is the hardest case to reach from the ports. It needs a first byte just below a 256 MB boundary, a length that carries the last byte over it, and direct-store flags that disagree. The stimulus sets the address a few bytes below the boundary, with sizes that cross it and sizes that stop just short of it. It pairs each with equal and unequal flags. Overlapping matches are built on purpose: a misaligned little-endian multiple access and a misaligned floating-point access in a direct-store segment. This shows that the encoder picks the lowest-numbered rule.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [2:0] {
        ACC_ELEM   = 3'd0,
        ACC_FP     = 3'd1,
        ACC_MULTI  = 3'd2,
        ACC_RSV    = 3'd3,
        ACC_STRING = 3'd4,
        ACC_BZERO  = 3'd5,
        ACC_EXTW   = 3'd6,
        ACC_SPARE  = 3'd7
    } acc_class_e;

    typedef enum logic [2:0] {
        CZ_NONE       = 3'd0,
        CZ_FP_DIRECT  = 3'd1,
        CZ_FP_WORD    = 3'd2,
        CZ_MW_WORD    = 3'd3,
        CZ_SEG_SPLIT  = 3'd4,
        CZ_BZERO_ATTR = 3'd5,
        CZ_EXT_WORD   = 3'd6,
        CZ_LE_BULK    = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        DC_ABSENT    = 2'd0,
        DC_WTHRU     = 2'd1,
        DC_CBACK     = 2'd2,
        DC_CBACK_ALT = 2'd3
    } dc_mode_e;

    localparam int RULE_COUNT = 7;
    localparam int CAUSE_W    = $clog2(RULE_COUNT + 1);

endpackage

// File: rtl/align_span.sv
module align_span #(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 8,
    parameter int SEG_BITS = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              word_misal_o,
    output logic              seg_split_o
);
    localparam int LOW_W = ADDR_W - SEG_BITS;

    logic [ADDR_W-1:0] span_m1;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] diff_bits;

    always_comb begin
        if (size_i == '0) begin
            span_m1 = '0;
        end else begin
            span_m1 = ADDR_W'(size_i) - ADDR_W'(1);
        end
        last_addr    = addr_i + span_m1;
        diff_bits    = addr_i ^ last_addr;
        seg_split_o  = (diff_bits >> LOW_W) != '0;
        word_misal_o = addr_i[1:0] != 2'b00;
    end
endmodule

// File: rtl/align_rules.sv
module align_rules
    import align_pkg::*;
(
    input  acc_class_e            acc_class_i,
    input  logic                  word_misal_i,
    input  logic                  seg_split_i,
    input  logic                  ds_first_i,
    input  logic                  ds_last_i,
    input  logic                  wthru_i,
    input  logic                  cinhib_i,
    input  dc_mode_e              dc_mode_i,
    input  logic                  le_mode_i,
    output logic [RULE_COUNT:1]   hits_o
);
    logic is_fp, is_mwr, is_segchk, is_bzero, is_extw, is_bulk;

    always_comb begin
        is_fp = 1'b0; is_mwr = 1'b0; is_segchk = 1'b0;
        is_bzero = 1'b0; is_extw = 1'b0; is_bulk = 1'b0;
        unique case (acc_class_i)
            ACC_ELEM:   is_segchk = 1'b1;
            ACC_FP:     is_fp     = 1'b1;
            ACC_MULTI:  begin is_mwr = 1'b1; is_segchk = 1'b1; is_bulk = 1'b1; end
            ACC_RSV:    is_mwr    = 1'b1;
            ACC_STRING: begin is_segchk = 1'b1; is_bulk = 1'b1; end
            ACC_BZERO:  is_bzero  = 1'b1;
            ACC_EXTW:   is_extw   = 1'b1;
            ACC_SPARE:  ;
            default:    ;
        endcase
    end

    logic cache_unfit;
    always_comb begin
        cache_unfit = wthru_i | cinhib_i |
                      (dc_mode_i == DC_ABSENT) | (dc_mode_i == DC_WTHRU);
        hits_o[CZ_FP_DIRECT]  = is_fp & (ds_first_i | ds_last_i);
        hits_o[CZ_FP_WORD]    = is_fp & word_misal_i;
        hits_o[CZ_MW_WORD]    = is_mwr & word_misal_i;
        hits_o[CZ_SEG_SPLIT]  = is_segchk & seg_split_i & (ds_first_i ^ ds_last_i);
        hits_o[CZ_BZERO_ATTR] = is_bzero & cache_unfit;
        hits_o[CZ_EXT_WORD]   = is_extw & word_misal_i;
        hits_o[CZ_LE_BULK]    = is_bulk & le_mode_i;
    end
endmodule

// File: rtl/align_prio.sv
module align_prio #(
    parameter int N      = 7,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [N:1]        hits_i,
    output logic [CODE_W-1:0] code_o
);
    logic [N:0] seen;
    logic [N:1] first;

    assign seen[0] = 1'b0;

    for (genvar g = 1; g <= N; g++) begin : g_chain
        assign first[g] = hits_i[g] & ~seen[g-1];
        assign seen[g]  = seen[g-1] | hits_i[g];
    end

    always_comb begin
        code_o = '0;
        for (int i = 1; i <= N; i++) begin
            if (first[i]) code_o = CODE_W'(i);
        end
    end
endmodule

// File: rtl/align_check.sv
module align_check
    import align_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 8,
    parameter int SEG_BITS = 4
) (
    input  logic [2:0]         acc_class_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic               ds_first_i,
    input  logic               ds_last_i,
    input  logic               wthru_i,
    input  logic               cinhib_i,
    input  logic [1:0]         dc_mode_i,
    input  logic               le_mode_i,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic                  word_misal;
    logic                  seg_split;
    logic [RULE_COUNT:1]   hits;

    align_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEG_BITS(SEG_BITS)) u_span (
        .addr_i       (addr_i),
        .size_i       (size_i),
        .word_misal_o (word_misal),
        .seg_split_o  (seg_split)
    );

    align_rules u_rules (
        .acc_class_i  (acc_class_e'(acc_class_i)),
        .word_misal_i (word_misal),
        .seg_split_i  (seg_split),
        .ds_first_i   (ds_first_i),
        .ds_last_i    (ds_last_i),
        .wthru_i      (wthru_i),
        .cinhib_i     (cinhib_i),
        .dc_mode_i    (dc_mode_e'(dc_mode_i)),
        .le_mode_i    (le_mode_i),
        .hits_o       (hits)
    );

    align_prio #(.N(RULE_COUNT), .CODE_W(CAUSE_W)) u_prio (
        .hits_i (hits),
        .code_o (cause_o)
    );

    assign fault_o = |hits;
endmodule

// File: rtl/align_check_sva.sv
module align_check_sva (
    input logic [2:0] acc_class_i,
    input logic [1:0] addr_lo,
    input logic       ds_first_i,
    input logic       ds_last_i,
    input logic       cinhib_i,
    input logic       le_mode_i,
    input logic       fault_o,
    input logic [2:0] cause_o
);
    always_comb begin
        // R1
        fp_direct_chk: assert (!(acc_class_i == 3'd1 && (ds_first_i || ds_last_i)) || cause_o == 3'd1)
            else $error("fp direct-store cause wrong");
        // R2
        fp_word_chk: assert (!(acc_class_i == 3'd1 && addr_lo != 2'b00) || fault_o)
            else $error("fp misaligned not flagged");
        // R3
        mw_word_chk: assert (!(acc_class_i == 3'd2 && addr_lo != 2'b00) || cause_o == 3'd3)
            else $error("multiple misaligned cause wrong");
        // R5
        bzero_ci_chk: assert (!(acc_class_i == 3'd5 && cinhib_i) || cause_o == 3'd5)
            else $error("block zero inhibited cause wrong");
        // R6
        extw_word_chk: assert (!(acc_class_i == 3'd6 && addr_lo != 2'b00) || cause_o == 3'd6)
            else $error("external word misaligned cause wrong");
        // R7
        le_bulk_chk: assert (!((acc_class_i == 3'd2 || acc_class_i == 3'd4) && le_mode_i) || fault_o)
            else $error("little-endian bulk access not flagged");
        // R8
        elem_only_split_chk: assert (acc_class_i != 3'd0 || cause_o == 3'd0 || cause_o == 3'd4)
            else $error("elementary access with foreign cause");
        // R9
        flag_cause_chk: assert (fault_o == (cause_o != 3'd0))
            else $error("fault flag and cause disagree");
    end
endmodule

bind align_check align_check_sva u_sva (
    .acc_class_i (acc_class_i),
    .addr_lo     (addr_i[1:0]),
    .ds_first_i  (ds_first_i),
    .ds_last_i   (ds_last_i),
    .cinhib_i    (cinhib_i),
    .le_mode_i   (le_mode_i),
    .fault_o     (fault_o),
    .cause_o     (cause_o)
);

// File: tb/sim_align_check.sv
module sim_align_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  acc_class;
    logic [31:0] addr;
    logic [7:0]  size;
    logic        ds_first, ds_last, wthru, cinhib, le_mode;
    logic [1:0]  dc_mode;
    logic        fault;
    logic [2:0]  cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [2:0] code;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    align_check u0 (
        .acc_class_i (acc_class),
        .addr_i      (addr),
        .size_i      (size),
        .ds_first_i  (ds_first),
        .ds_last_i   (ds_last),
        .wthru_i     (wthru),
        .cinhib_i    (cinhib),
        .dc_mode_i   (dc_mode),
        .le_mode_i   (le_mode),
        .fault_o     (fault),
        .cause_o     (cause)
    );

    function automatic logic [2:0] model(input logic [2:0] c, input logic [31:0] a,
                                         input logic [7:0] s, input logic df, input logic dl,
                                         input logic wt, input logic ci, input logic [1:0] dm,
                                         input logic le);
        logic [31:0] last;
        logic        mis, split;
        last  = a + ((s == 0) ? 32'd0 : {24'd0, s} - 32'd1);
        mis   = a[1:0] != 0;
        split = a[31:28] != last[31:28];
        if (c == 1 && (df || dl))                           return 3'd1;
        if (c == 1 && mis)                                  return 3'd2;
        if ((c == 2 || c == 3) && mis)                      return 3'd3;
        if ((c == 0 || c == 2 || c == 4) && split && df != dl) return 3'd4;
        if (c == 5 && (wt || ci || dm < 2))                 return 3'd5;
        if (c == 6 && mis)                                  return 3'd6;
        if ((c == 2 || c == 4) && le)                       return 3'd7;
        return 3'd0;
    endfunction

    task automatic apply(input logic [2:0] c, input logic [31:0] a, input logic [7:0] s,
                         input logic df, input logic dl, input logic wt, input logic ci,
                         input logic [1:0] dm, input logic le, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        acc_class = c; addr = a; size = s; ds_first = df; ds_last = dl;
        wthru = wt; cinhib = ci; dc_mode = dm; le_mode = le;
        e.code = model(c, a, s, df, dl, wt, ci, dm, le);
        e.tag  = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (cause !== e.code || fault !== (e.code != 0)) begin
                n_fails++;
                $display("FAIL %s: cause=%0d fault=%0b expected cause=%0d fault=%0b",
                         e.tag, cause, fault, e.code, (e.code != 0));
            end
        end
    end

    initial begin
        acc_class = 0; addr = 0; size = 1; ds_first = 0; ds_last = 0;
        wthru = 0; cinhib = 0; dc_mode = 2; le_mode = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state after reset: R9
        apply(0, 32'h0, 1, 0, 0, 0, 0, 2, 0, "R9 idle");
        // R1
        apply(1, 32'h100, 8, 1, 0, 0, 0, 2, 0, "R1 ds first");
        apply(1, 32'h100, 8, 0, 1, 0, 0, 2, 0, "R1 ds last");
        apply(1, 32'h102, 8, 1, 1, 0, 0, 2, 0, "R1 over R2 priority");
        // R2
        apply(1, 32'h102, 4, 0, 0, 0, 0, 2, 0, "R2 fp misaligned");
        apply(1, 32'h104, 8, 0, 0, 1, 1, 0, 1, "R2 fp aligned clean");
        // R3
        apply(2, 32'h201, 16, 0, 0, 0, 0, 2, 0, "R3 multi misaligned");
        apply(3, 32'h203, 4, 0, 0, 0, 0, 2, 0, "R3 reserve misaligned");
        apply(3, 32'h204, 4, 0, 0, 0, 0, 2, 1, "R3 reserve aligned");
        apply(2, 32'h202, 8, 0, 0, 0, 0, 2, 1, "R3 over R7 priority");
        // R4
        apply(0, 32'h0FFF_FFFE, 4, 0, 1, 0, 0, 2, 0, "R4 elem split ds differ");
        apply(0, 32'h0FFF_FFFE, 4, 1, 1, 0, 0, 2, 0, "R4 elem split ds same");
        apply(0, 32'h0FFF_FFFC, 4, 0, 1, 0, 0, 2, 0, "R4 elem ends at boundary");
        apply(4, 32'h1FFF_FFF0, 32, 1, 0, 0, 0, 2, 0, "R4 string split");
        apply(2, 32'hFFFF_FFFC, 8, 0, 1, 0, 0, 2, 1, "R4 multi wrap over R7");
        apply(0, 32'h3FFF_FFFF, 0, 0, 1, 0, 0, 2, 0, "R4 size zero one byte");
        // R5
        apply(5, 32'h400, 32, 0, 0, 1, 0, 2, 0, "R5 write-through page");
        apply(5, 32'h400, 32, 0, 0, 0, 1, 3, 0, "R5 inhibited page");
        apply(5, 32'h400, 32, 0, 0, 0, 0, 0, 0, "R5 no data cache");
        apply(5, 32'h400, 32, 0, 0, 0, 0, 1, 0, "R5 write-through cache");
        apply(5, 32'h401, 32, 0, 0, 0, 0, 2, 1, "R5 copy-back clean");
        apply(5, 32'h400, 32, 0, 0, 0, 0, 3, 0, "R5 copy-back alt clean");
        // R6
        apply(6, 32'h502, 4, 0, 0, 0, 0, 2, 0, "R6 ext misaligned");
        apply(6, 32'h504, 4, 0, 0, 0, 0, 2, 1, "R6 ext aligned");
        // R7
        apply(2, 32'h600, 16, 0, 0, 0, 0, 2, 1, "R7 multi le");
        apply(4, 32'h603, 5, 0, 0, 0, 0, 2, 1, "R7 string le");
        apply(4, 32'h603, 5, 0, 0, 0, 0, 2, 0, "R7 string be clean");
        // R8
        apply(0, 32'h703, 4, 0, 0, 1, 1, 0, 1, "R8 elem misaligned le");
        apply(0, 32'h701, 2, 1, 1, 0, 0, 2, 0, "R8 elem misaligned be");
        // R9 spare class
        apply(7, 32'h803, 4, 1, 0, 1, 1, 0, 1, "R9 spare class");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule